// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block links two bidirectional data ports, A and B, through a pair of transfer lanes. The A-to-B lane drives port B and the B-to-A lane drives port A. Each lane has a storage register that captures the value on its source port on the rising edge of a capture strobe. Each lane also has a pick input. When the pick is low, the lane forwards the live value of the opposite port. When the pick is high, the lane drives the stored value. The B-side drivers turn on when an active-high enable is set. The A-side drivers turn on when an active-low enable is cleared. Neither capture strobe is qualified by the enables or the picks.

Every tri-state pin is split into an external value, an external-driver-present flag, and the block's own output and output enable. The value on a port resolves with a fixed priority: an external driver wins first, then the block's driver if it is enabled, and otherwise a per-port bus keeper that holds the last value the port carried. The capture strobes are sampled on the system clock, so a capture is a rising edge of a strobe as seen at a clock edge. When both lanes drive live data, the ports reinforce each other. The keepers then freeze, and that feedback loop holds the last value on both ports. The data width is the parameter `W` (default 8).

Top module: `dual_xcvr`

## Requirements
- R1: A synchronous active-low reset clears both storage registers and both port keepers to zero.
- R2: The A-side register loads the resolved port A value at a clock edge where `stb_a2b` is 1 and was 0 at the previous edge. The B-side register does the same with `stb_b2a` and port B. The registers do not change while a strobe stays low or stays high.
- R3: A capture is independent of the enables and picks, including while the lane's own source port is being driven by the block.
- R4: `pick_a2b`=0 drives port B with the live port A value, and `pick_a2b`=1 drives it from the A-side register. `pick_b2a` applies the same rule toward port A. Outputs follow the picks and the live sources in the same cycle.
- R5: `pb_oe` equals `en_a2b` (active high), and `pa_oe` equals the inverse of `en_b2a_n` (active low), both combinationally.
- R6: With `en_a2b`=0 and `en_b2a_n`=1 (isolation), neither port is driven, yet either register can still capture from its port.
- R7: With both drivers enabled and both picks high, port B shows the A-side register and port A shows the B-side register at the same time.
- R8: With both drivers enabled, both picks low and no external driver on either port, both keepers hold. Both outputs keep the last value the ports carried.
- R9: When A drives B live and both strobes rise at the same edge, both registers capture the port A value.
- R10: A port with no external driver and with its own drivers off presents its keeper value (the last value it carried) as the live source for the opposite port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stb_a2b | input | 1 | Capture strobe for the A-side register (rising edge loads) |
| stb_b2a | input | 1 | Capture strobe for the B-side register (rising edge loads) |
| pick_a2b | input | 1 | Source for port B: 0 live A, 1 stored A |
| pick_b2a | input | 1 | Source for port A: 0 live B, 1 stored B |
| en_a2b | input | 1 | Active-high enable for the port B drivers |
| en_b2a_n | input | 1 | Active-low enable for the port A drivers |
| pa_i | input | W | Value from the external driver on port A |
| pa_ext | input | 1 | An external driver is present on port A |
| pa_o | output | W | Block's drive value for port A |
| pa_oe | output | 1 | Block drives port A |
| pb_i | input | W | Value from the external driver on port B |
| pb_ext | input | 1 | An external driver is present on port B |
| pb_o | output | W | Block's drive value for port B |
| pb_oe | output | 1 | Block drives port B |

## Verification
The bench holds a strobe high for several cycles while it changes the port value. A design that loads on level instead of on edge would then show the newer value on the stored path. It captures during isolation, which catches a strobe wrongly gated by the enables. It pulses both strobes while A drives B live, which catches a B register fed from the raw external pin instead of the resolved port. It also closes the live loop after releasing the external driver. A keeper that kept updating in the loop would swap or drift values between the ports instead of holding them.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  typedef enum logic {
    PICK_LIVE   = 1'b0,
    PICK_STORED = 1'b1
  } pick_e;
endpackage

// File: rtl/xcvr_capture_reg.sv
`timescale 1ns/1ps
// Storage register that loads on a rising edge of its strobe as seen at clk.
module xcvr_capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic stb_q;
  logic rise;

  assign rise = stb && !stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      q     <= '0;
    end else begin
      stb_q <= stb;
      if (rise) q <= d;
    end
  end
endmodule

// File: rtl/xcvr_dir_lane.sv
`timescale 1ns/1ps
// One transfer direction: source pick and enable decode.
module xcvr_dir_lane
  import xcvr_pkg::*;
#(
  parameter int W          = 8,
  parameter bit EN_ACT_LOW = 1'b0
) (
  input  logic         pick,
  input  logic         en,
  input  logic [W-1:0] live_val,
  input  logic [W-1:0] stored_val,
  output logic [W-1:0] drv_val,
  output logic         drv_oe,
  output logic         stored_drv
);
  logic use_stored;

  assign use_stored = (pick == PICK_STORED);

  generate
    if (EN_ACT_LOW) begin : g_en_low
      assign drv_oe = !en;
    end else begin : g_en_high
      assign drv_oe = en;
    end
  endgenerate

  assign drv_val    = use_stored ? stored_val : live_val;
  assign stored_drv = drv_oe && use_stored;
endmodule

// File: rtl/xcvr_port_node.sv
`timescale 1ns/1ps
// Port resolution plus bus keeper.
// src_val: value offered to the opposite lane's live path, formed without the
// block's live drive so that the two live paths never close a combinational loop.
// wire_val: full resolved value of the port, used for capture and keeper update.
module xcvr_port_node #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext,
  input  logic [W-1:0] ext_val,
  input  logic         drv_oe,
  input  logic [W-1:0] drv_val,
  input  logic         stored_drv,
  input  logic [W-1:0] stored_val,
  input  logic         hold,
  output logic [W-1:0] src_val,
  output logic [W-1:0] wire_val,
  output logic [W-1:0] keep_val
);
  logic [W-1:0] keep_q;
  logic         upd;

  always_comb begin
    if (ext)             src_val = ext_val;
    else if (stored_drv) src_val = stored_val;
    else                 src_val = keep_q;
  end

  always_comb begin
    if (ext)         wire_val = ext_val;
    else if (drv_oe) wire_val = drv_val;
    else             wire_val = keep_q;
  end

  assign upd = !hold && (ext || drv_oe);

  always_ff @(posedge clk) begin
    if (!rst_n)   keep_q <= '0;
    else if (upd) keep_q <= wire_val;
  end

  assign keep_val = keep_q;
endmodule

// File: rtl/dual_xcvr.sv
`timescale 1ns/1ps
module dual_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb_a2b,
  input  logic         stb_b2a,
  input  logic         pick_a2b,
  input  logic         pick_b2a,
  input  logic         en_a2b,
  input  logic         en_b2a_n,
  input  logic [W-1:0] pa_i,
  input  logic         pa_ext,
  output logic [W-1:0] pa_o,
  output logic         pa_oe,
  input  logic [W-1:0] pb_i,
  input  logic         pb_ext,
  output logic [W-1:0] pb_o,
  output logic         pb_oe
);
  logic [W-1:0] reg_a_q, reg_b_q;
  logic [W-1:0] a_src, b_src, a_wire, b_wire, keep_a, keep_b;
  logic         a_stored_drv, b_stored_drv;
  logic         loop_hold;

  // Both lanes live, both driving, nothing external: the loop holds itself.
  assign loop_hold = pa_oe && pb_oe && !pick_a2b && !pick_b2a && !pa_ext && !pb_ext;

  xcvr_capture_reg #(.W(W)) u_reg_a (
    .clk(clk), .rst_n(rst_n), .stb(stb_a2b), .d(a_wire), .q(reg_a_q)
  );

  xcvr_capture_reg #(.W(W)) u_reg_b (
    .clk(clk), .rst_n(rst_n), .stb(stb_b2a), .d(b_wire), .q(reg_b_q)
  );

  xcvr_dir_lane #(.W(W), .EN_ACT_LOW(1'b0)) u_lane_a2b (
    .pick(pick_a2b), .en(en_a2b), .live_val(a_src), .stored_val(reg_a_q),
    .drv_val(pb_o), .drv_oe(pb_oe), .stored_drv(b_stored_drv)
  );

  xcvr_dir_lane #(.W(W), .EN_ACT_LOW(1'b1)) u_lane_b2a (
    .pick(pick_b2a), .en(en_b2a_n), .live_val(b_src), .stored_val(reg_b_q),
    .drv_val(pa_o), .drv_oe(pa_oe), .stored_drv(a_stored_drv)
  );

  xcvr_port_node #(.W(W)) u_node_a (
    .clk(clk), .rst_n(rst_n), .ext(pa_ext), .ext_val(pa_i),
    .drv_oe(pa_oe), .drv_val(pa_o), .stored_drv(a_stored_drv),
    .stored_val(reg_b_q), .hold(loop_hold),
    .src_val(a_src), .wire_val(a_wire), .keep_val(keep_a)
  );

  xcvr_port_node #(.W(W)) u_node_b (
    .clk(clk), .rst_n(rst_n), .ext(pb_ext), .ext_val(pb_i),
    .drv_oe(pb_oe), .drv_val(pb_o), .stored_drv(b_stored_drv),
    .stored_val(reg_a_q), .hold(loop_hold),
    .src_val(b_src), .wire_val(b_wire), .keep_val(keep_b)
  );
endmodule

// File: rtl/dual_xcvr_chk.sv
`timescale 1ns/1ps
module dual_xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stb_a2b,
  input logic         stb_b2a,
  input logic         pick_a2b,
  input logic         pick_b2a,
  input logic         en_a2b,
  input logic         en_b2a_n,
  input logic [W-1:0] pa_i,
  input logic         pa_ext,
  input logic [W-1:0] pa_o,
  input logic         pa_oe,
  input logic [W-1:0] pb_o,
  input logic         pb_oe,
  input logic         pb_ext,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic [W-1:0] a_wire,
  input logic [W-1:0] b_wire,
  input logic [W-1:0] keep_a,
  input logic [W-1:0] keep_b
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (reg_a == '0 && reg_b == '0 && keep_a == '0 && keep_b == '0));

  a_r2_load_a_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_a2b) |=> reg_a == $past(a_wire));

  a_r2_load_b_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_b2a) |=> reg_b == $past(b_wire));

  a_r2_a_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_a2b |=> $stable(reg_a));

  a_r2_b_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_b2a |=> $stable(reg_b));

  a_r4_stored_to_b: assert property (@(posedge clk) disable iff (!rst_n)
    pick_a2b |-> pb_o == reg_a);

  a_r4_live_to_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!pick_a2b && pa_ext) |-> pb_o == pa_i);

  a_r5_b_enable_high: assert property (@(posedge clk) disable iff (!rst_n)
    en_a2b |-> pb_oe);

  a_r5_a_enable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en_b2a_n |-> pa_oe);

  a_r6_isolation: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_a2b && en_b2a_n) |-> (!pa_oe && !pb_oe));

  a_r7_both_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe && pb_oe && pick_a2b && pick_b2a) |-> (pb_o == reg_a && pa_o == reg_b));

  a_r8_loop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe && pb_oe && !pick_a2b && !pick_b2a && !pa_ext && !pb_ext)
      |=> ($stable(keep_a) && $stable(keep_b)));
endmodule

bind dual_xcvr dual_xcvr_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb_a2b(stb_a2b), .stb_b2a(stb_b2a),
  .pick_a2b(pick_a2b), .pick_b2a(pick_b2a), .en_a2b(en_a2b), .en_b2a_n(en_b2a_n),
  .pa_i(pa_i), .pa_ext(pa_ext), .pa_o(pa_o), .pa_oe(pa_oe),
  .pb_o(pb_o), .pb_oe(pb_oe), .pb_ext(pb_ext),
  .reg_a(reg_a_q), .reg_b(reg_b_q), .a_wire(a_wire), .b_wire(b_wire),
  .keep_a(keep_a), .keep_b(keep_b)
);

// File: tb/dual_xcvr_bench.sv
`timescale 1ns/1ps
module dual_xcvr_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic stb_a2b = 0, stb_b2a = 0, pick_a2b = 0, pick_b2a = 0;
  logic en_a2b = 0, en_b2a_n = 1, pa_ext = 0, pb_ext = 0;
  logic [W-1:0] pa_i = '0, pb_i = '0;
  logic [W-1:0] pa_o, pb_o;
  logic pa_oe, pb_oe;

  dual_xcvr #(.W(W)) u_dual_xcvr (
    .clk(clk), .rst_n(rst_n), .stb_a2b(stb_a2b), .stb_b2a(stb_b2a),
    .pick_a2b(pick_a2b), .pick_b2a(pick_b2a), .en_a2b(en_a2b), .en_b2a_n(en_b2a_n),
    .pa_i(pa_i), .pa_ext(pa_ext), .pa_o(pa_o), .pa_oe(pa_oe),
    .pb_i(pb_i), .pb_ext(pb_ext), .pb_o(pb_o), .pb_oe(pb_oe)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference state derived from the requirements
  logic [W-1:0] m_ra = '0, m_rb = '0, m_ka = '0, m_kb = '0;
  logic m_pa = 0, m_pb = 0;

  function automatic logic [W-1:0] m_src_a();
    return pa_ext ? pa_i : ((!en_b2a_n && pick_b2a) ? m_rb : m_ka);
  endfunction
  function automatic logic [W-1:0] m_src_b();
    return pb_ext ? pb_i : ((en_a2b && pick_a2b) ? m_ra : m_kb);
  endfunction
  function automatic logic [W-1:0] exp_pb_o();
    return pick_a2b ? m_ra : m_src_a();
  endfunction
  function automatic logic [W-1:0] exp_pa_o();
    return pick_b2a ? m_rb : m_src_b();
  endfunction
  function automatic logic [W-1:0] m_wire_a();
    return pa_ext ? pa_i : (!en_b2a_n ? exp_pa_o() : m_ka);
  endfunction
  function automatic logic [W-1:0] m_wire_b();
    return pb_ext ? pb_i : (en_a2b ? exp_pb_o() : m_kb);
  endfunction
  function automatic bit m_loop();
    return !en_b2a_n && en_a2b && !pick_a2b && !pick_b2a && !pa_ext && !pb_ext;
  endfunction
  function automatic string auto_tag();
    if (m_loop()) return "R8";
    if (!en_b2a_n && en_a2b && pick_a2b && pick_b2a) return "R7";
    if (!pa_ext && en_b2a_n && !pick_a2b) return "R10";
    return "R4";
  endfunction

  task automatic chk_eq(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge with inputs set; checks, then advances one clock.
  task automatic cycle(input string tag);
    string t;
    string oe_tag;
    logic [W-1:0] nra, nrb, nka, nkb;
    t = (tag == "") ? auto_tag() : tag;
    oe_tag = (!en_a2b && en_b2a_n) ? "R6" : "R5";
    #1;
    chk_eq(oe_tag, {{(W-1){1'b0}}, pa_oe}, {{(W-1){1'b0}}, !en_b2a_n});
    chk_eq(oe_tag, {{(W-1){1'b0}}, pb_oe}, {{(W-1){1'b0}}, en_a2b});
    chk_eq(t, pa_o, exp_pa_o());
    chk_eq(t, pb_o, exp_pb_o());
    nra = (stb_a2b && !m_pa) ? m_wire_a() : m_ra;
    nrb = (stb_b2a && !m_pb) ? m_wire_b() : m_rb;
    nka = (!m_loop() && (pa_ext || !en_b2a_n)) ? m_wire_a() : m_ka;
    nkb = (!m_loop() && (pb_ext || en_a2b)) ? m_wire_b() : m_kb;
    @(posedge clk);
    m_ra = nra; m_rb = nrb; m_ka = nka; m_kb = nkb;
    m_pa = stb_a2b; m_pb = stb_b2a;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: stored paths read zero after reset
    en_a2b = 1; pick_a2b = 1; en_b2a_n = 0; pick_b2a = 1;
    #1 chk_eq("R1", pb_o, '0); chk_eq("R1", pa_o, '0);
    @(negedge clk);
    cycle("R1");

    // R2: level-held strobe loads only once
    en_b2a_n = 1; pa_ext = 1; pa_i = 8'h3C; stb_a2b = 1;
    cycle("R2");
    pa_i = 8'h81;
    cycle("R2"); cycle("R2");
    #1 chk_eq("R2", pb_o, 8'h3C);
    @(negedge clk);
    stb_a2b = 0; cycle("R2");
    stb_a2b = 1; cycle("R2");
    #1 chk_eq("R2", pb_o, 8'h81);
    @(negedge clk);
    stb_a2b = 0;

    // R3 / R6: capture during isolation
    en_a2b = 0; en_b2a_n = 1; pb_ext = 1; pb_i = 8'hE7; stb_b2a = 1;
    cycle("R6");
    stb_b2a = 0; pb_ext = 0; en_b2a_n = 0; pick_b2a = 1;
    #1 chk_eq("R3", pa_o, 8'hE7);
    @(negedge clk);
    cycle("R3");

    // R7: both stored values out together
    en_a2b = 1; pick_a2b = 1; pa_ext = 0;
    #1 chk_eq("R7", pb_o, 8'h81); chk_eq("R7", pa_o, 8'hE7);
    @(negedge clk);
    cycle("R7");

    // R9: A live onto B, both strobes rise
    pa_ext = 1; pa_i = 8'h96; pick_a2b = 0; en_a2b = 1; en_b2a_n = 1;
    stb_a2b = 1; stb_b2a = 1;
    cycle("R9");
    stb_a2b = 0; stb_b2a = 0; pa_ext = 0;
    pick_a2b = 1; pick_b2a = 1; en_b2a_n = 0;
    #1 chk_eq("R9", pb_o, 8'h96); chk_eq("R9", pa_o, 8'h96);
    @(negedge clk);
    cycle("R9");

    // R8: live loop holds after external release
    pa_ext = 1; pa_i = 8'h5A; pick_a2b = 0; en_a2b = 1; en_b2a_n = 1;
    cycle("R8");
    en_b2a_n = 0; pick_b2a = 0; pa_ext = 0;
    cycle("R8"); cycle("R8"); cycle("R8");
    #1 chk_eq("R8", pa_o, 8'h5A); chk_eq("R8", pb_o, 8'h5A);
    @(negedge clk);

    // R10: undriven port forwards its keeper value
    en_b2a_n = 1;
    #1 chk_eq("R10", pb_o, 8'h5A);
    @(negedge clk);
    cycle("R10");
    pa_ext = 1; pa_i = 8'hC3;
    cycle("R10");
    pa_ext = 0;
    #1 chk_eq("R10", pb_o, 8'hC3);
    @(negedge clk);

    // Random mix, checked against the reference state
    for (int i = 0; i < 600; i++) begin
      stb_a2b  = $urandom_range(0, 1);
      stb_b2a  = $urandom_range(0, 1);
      pick_a2b = $urandom_range(0, 1);
      pick_b2a = $urandom_range(0, 1);
      en_a2b   = ($urandom_range(0, 3) != 0);
      en_b2a_n = ($urandom_range(0, 3) == 0);
      pa_ext   = ($urandom_range(0, 2) == 0);
      pb_ext   = ($urandom_range(0, 2) == 0);
      pa_i     = W'($urandom);
      pb_i     = W'($urandom);
      cycle("");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule